// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when a small microcontroller leaves its run state for one of its standby modes, and when it comes back. Software writes a three-bit control word holding a sleep request, a timer-mode bit and a stop request. The controller decodes that word with fixed priorities: stop wins over timer mode, and timer mode wins over sleep. When sleep is chosen, the clock-select inputs pick one of three sleep variants. The block drives separate registered enables for the CPU clock, the peripheral clock and the time-base-timer clock. It also reports the current mode, drives a pin-hold request for the non-bus pads, and grants external bus hold requests.

An interrupt that is already pending when an entry request is written refuses the entry. An interrupt that arrives in any low-power mode returns the controller to the run mode that matches the clock selection on the next clock edge. All control signals are plain level pins. The write strobe is a single-cycle pulse, and the block has no back-pressure, because it accepts or refuses a write in the same cycle.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, mode_o is 1 (main run), cpu_clk_en, per_clk_en and tbt_clk_en are 1, hold_ack and pin_hold are 0, and ctl_rdata is 3'b010.
- R2: A write in a run mode with bit0 (sleep) = 1, bit1 (timer-mode) = 1 and bit2 (stop) = 0, with no pending interrupt, enters a sleep mode on that edge. The sleep variant is chosen as follows:
  - sel_main = 0 with sel_sub = 1 gives mode 3 (PLL sleep).
  - sel_main = 1 with sel_sub = 1 gives mode 4 (main sleep).
  - sel_sub = 0 gives mode 5 (sub-clock sleep).
  - In every sleep variant, cpu_clk_en = 0 while per_clk_en = 1 and tbt_clk_en = 1.
- R3: A write with bit2 = 1 enters mode 7 (stop) whatever bit0 and bit1 hold, and all three clock enables go to 0.
- R4: A write with bit0 = 1, bit1 = 0 and bit2 = 0 enters mode 6 (timer). Only tbt_clk_en stays 1.
- R5: If irq_pending is 1 in the cycle of a write that has bit0 or bit2 set, no transition occurs and cpu_clk_en stays 1.
- R6: In any low-power mode (3 to 7), irq_pending = 1 returns the block on the next edge to a run mode: 0 (PLL run) for sel_main = 0 with sel_sub = 1, 1 (main run) for sel_main = 1 with sel_sub = 1, and 2 (sub run) for sel_sub = 0. In a run mode, mode_o follows the clock selection at each edge.
- R7: hold_ack is registered. It is 1 one edge after hold_req is sampled high while the mode resulting from that edge is a run or sleep mode. It is 0 in timer and stop.
- R8: pin_hold is 1 exactly while the mode is a low-power mode (3 to 7).
- R9: ctl_rdata bit1 returns the timer-mode bit of the last accepted write. Bits 0 and 2 always read 0, because the requests clear themselves.
- R10: Writes that arrive while the mode is a low-power mode are ignored: neither the mode nor the readback changes.
- R11: A write with bit0 = 0 and bit2 = 0 causes no mode transition.
- R12: All outputs change only at a clock edge, from registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 3 | Control word: bit0 sleep, bit1 timer-mode, bit2 stop |
| ctl_rdata | output | 3 | Control word readback |
| sel_main | input | 1 | Main-clock select (0 selects the PLL when sel_sub is 1) |
| sel_sub | input | 1 | 0 selects the sub clock |
| irq_pending | input | 1 | An enabled interrupt request is pending |
| hold_req | input | 1 | External bus hold request |
| hold_ack | output | 1 | External bus hold grant |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| tbt_clk_en | output | 1 | Time-base-timer clock enable |
| pin_hold | output | 1 | Hold the non-bus pad levels |
| mode_o | output | 3 | Current mode code, 0 to 7 |

## Verification
The hardest case to reach from the ports is a collision of events in one cycle. One such case is an entry write arriving in the same cycle as a pending interrupt. Another is a wake-up arriving in the same cycle as a change of the clock selection. A third is a hold request toggling across an entry into or out of timer or stop mode. Directed sequences place these events in the same cycle for each clock selection. A long stretch of seeded random strobes, selections, interrupts and hold requests then runs against a behavioural reference model, and every output is compared on every clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int CTL_W  = 3;
  localparam int B_SLP  = 0;
  localparam int B_TMD  = 1;
  localparam int B_STP  = 2;

  typedef enum logic [2:0] {
    M_RUN_PLL  = 3'd0,
    M_RUN_MAIN = 3'd1,
    M_RUN_SUB  = 3'd2,
    M_SLP_PLL  = 3'd3,
    M_SLP_MAIN = 3'd4,
    M_SLP_SUB  = 3'd5,
    M_TIMER    = 3'd6,
    M_STOP     = 3'd7
  } mode_t;

  function automatic mode_t run_variant(input logic sm, input logic ss);
    if (!ss)     return M_RUN_SUB;
    else if (sm) return M_RUN_MAIN;
    else         return M_RUN_PLL;
  endfunction

  function automatic mode_t sleep_variant(input logic sm, input logic ss);
    if (!ss)     return M_SLP_SUB;
    else if (sm) return M_SLP_MAIN;
    else         return M_SLP_PLL;
  endfunction

  function automatic logic is_run(input mode_t m);
    return (m == M_RUN_PLL) || (m == M_RUN_MAIN) || (m == M_RUN_SUB);
  endfunction

  function automatic logic is_sleep(input mode_t m);
    return (m == M_SLP_PLL) || (m == M_SLP_MAIN) || (m == M_SLP_SUB);
  endfunction
endpackage

// File: rtl/lpm_decode.sv
module lpm_decode
  import lpm_pkg::*;
(
  input  mode_t             cur,
  input  logic              wr,
  input  logic [CTL_W-1:0]  wdata,
  input  logic              irq,
  input  logic              sm,
  input  logic              ss,
  output mode_t             nxt,
  output logic              accept_wr
);
  logic entry_req;

  always_comb begin
    accept_wr = wr && is_run(cur);
    entry_req = wdata[B_SLP] || wdata[B_STP];
    nxt       = cur;
    if (!is_run(cur)) begin
      if (irq) nxt = run_variant(sm, ss);
    end else if (accept_wr && entry_req && !irq) begin
      if (wdata[B_STP])       nxt = M_STOP;
      else if (!wdata[B_TMD]) nxt = M_TIMER;
      else                    nxt = sleep_variant(sm, ss);
    end else begin
      nxt = run_variant(sm, ss);
    end
  end
endmodule

// File: rtl/lpm_state.sv
module lpm_state
  import lpm_pkg::*;
#(
  parameter logic TMD_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             nxt,
  input  logic              accept_wr,
  input  logic [CTL_W-1:0]  wdata,
  output mode_t             cur,
  output logic [CTL_W-1:0]  rdata
);
  logic tmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= M_RUN_MAIN;
      tmd_q <= TMD_RST;
    end else begin
      cur <= nxt;
      if (accept_wr) tmd_q <= wdata[B_TMD];
    end
  end

  always_comb begin
    rdata        = '0;
    rdata[B_TMD] = tmd_q;
  end
endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
  import lpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t nxt,
  input  logic  hold_req,
  output logic  cpu_clk_en,
  output logic  per_clk_en,
  output logic  tbt_clk_en,
  output logic  pin_hold,
  output logic  hold_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      tbt_clk_en <= 1'b1;
      pin_hold   <= 1'b0;
      hold_ack   <= 1'b0;
    end else begin
      cpu_clk_en <= is_run(nxt);
      per_clk_en <= is_run(nxt) || is_sleep(nxt);
      tbt_clk_en <= (nxt != M_STOP);
      pin_hold   <= !is_run(nxt);
      hold_ack   <= hold_req && (is_run(nxt) || is_sleep(nxt));
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter logic TMD_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              sel_main,
  input  logic              sel_sub,
  input  logic              irq_pending,
  input  logic              hold_req,
  output logic              hold_ack,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              tbt_clk_en,
  output logic              pin_hold,
  output logic [2:0]        mode_o
);
  mode_t cur, nxt;
  logic  accept_wr;

  lpm_decode u_dec (
    .cur(cur), .wr(ctl_wr), .wdata(ctl_wdata), .irq(irq_pending),
    .sm(sel_main), .ss(sel_sub), .nxt(nxt), .accept_wr(accept_wr)
  );

  lpm_state #(.TMD_RST(TMD_RST)) u_st (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .accept_wr(accept_wr),
    .wdata(ctl_wdata), .cur(cur), .rdata(ctl_rdata)
  );

  lpm_gate u_gate (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .hold_req(hold_req),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .tbt_clk_en(tbt_clk_en), .pin_hold(pin_hold), .hold_ack(hold_ack)
  );

  assign mode_o = cur;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [2:0] ctl_wdata,
  input logic       irq_pending,
  input logic       hold_req,
  input logic       hold_ack,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       tbt_clk_en,
  input logic       pin_hold,
  input logic [2:0] mode_o
);
  logic in_run;
  assign in_run = (mode_o < 3'd3);

  assert_stop_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && ctl_wr && ctl_wdata[2] && !irq_pending) |=> (mode_o == 3'd7 && !tbt_clk_en));

  assert_irq_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && ctl_wr && irq_pending) |=> (cpu_clk_en && mode_o < 3'd3));

  assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run && irq_pending) |=> (cpu_clk_en && mode_o < 3'd3));

  assert_hold_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (mode_o < 3'd6 && $past(hold_req)));

  assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hold |-> !cpu_clk_en);

  assert_timer_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd6) |-> (!per_clk_en && tbt_clk_en && !cpu_clk_en));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .irq_pending(irq_pending), .hold_req(hold_req), .hold_ack(hold_ack),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .tbt_clk_en(tbt_clk_en),
  .pin_hold(pin_hold), .mode_o(mode_o)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = 3'b000;
  logic [2:0] ctl_rdata;
  logic       sel_main = 1'b1, sel_sub = 1'b1;
  logic       irq_pending = 1'b0, hold_req = 1'b0;
  logic       hold_ack, cpu_clk_en, per_clk_en, tbt_clk_en, pin_hold;
  logic [2:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_mode = 1;
  int m_tmd = 1;
  int m_hold = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sel_main(sel_main), .sel_sub(sel_sub),
    .irq_pending(irq_pending), .hold_req(hold_req), .hold_ack(hold_ack),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .tbt_clk_en(tbt_clk_en),
    .pin_hold(pin_hold), .mode_o(mode_o)
  );

  function automatic int run_of(input logic sm, input logic ss);
    if (!ss) return 2;
    return sm ? 1 : 0;
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 1; m_tmd = 1; m_hold = 0;
    end else begin
      if (m_mode >= 3) begin
        if (irq_pending) m_mode = run_of(sel_main, sel_sub);
      end else if (ctl_wr) begin
        m_tmd = ctl_wdata[1];
        if ((ctl_wdata[0] || ctl_wdata[2]) && !irq_pending) begin
          if (ctl_wdata[2])      m_mode = 7;
          else if (!ctl_wdata[1]) m_mode = 6;
          else                   m_mode = run_of(sel_main, sel_sub) + 3;
        end else m_mode = run_of(sel_main, sel_sub);
      end else m_mode = run_of(sel_main, sel_sub);
      m_hold = (hold_req && m_mode <= 5) ? 1 : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the model on each falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3/R4/R6/R10/R11 mode", mode_o, m_mode);
      chk("R2 R12 cpu_clk_en", cpu_clk_en, (m_mode <= 2) ? 1 : 0);
      chk("R4 per_clk_en", per_clk_en, (m_mode <= 5) ? 1 : 0);
      chk("R3 tbt_clk_en", tbt_clk_en, (m_mode != 7) ? 1 : 0);
      chk("R8 pin_hold", pin_hold, (m_mode >= 3) ? 1 : 0);
      chk("R7 hold_ack", hold_ack, m_hold);
      chk("R9 ctl_rdata", ctl_rdata, m_tmd << 1);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 3'b000;
  endtask

  task automatic wake();
    @(negedge clk); irq_pending = 1'b1;
    @(negedge clk); irq_pending = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R1: reset values, checked directly before the first active edge
    chk("R1 mode", mode_o, 1);
    chk("R1 clocks", {cpu_clk_en, per_clk_en, tbt_clk_en}, 7);
    chk("R1 hold/pin", {hold_ack, pin_hold}, 0);
    chk("R1 rdata", ctl_rdata, 3'b010);

    // R2: the sleep variant for each clock selection, plus hold (R7) and wake (R6)
    for (int s = 0; s < 3; s++) begin
      sel_main = (s == 1); sel_sub = (s != 2);
      cyc(2);
      wr(3'b011);
      hold_req = 1'b1; cyc(3); hold_req = 1'b0;
      wr(3'b100);                       // R10: write during sleep ignored
      cyc(2);
      wake();
      cyc(2);
    end
    // R3: stop wins, with every combination of the other bits
    for (int d = 4; d < 8; d++) begin
      wr(d[2:0]); hold_req = 1'b1; cyc(2); hold_req = 1'b0; wake(); cyc(1);
    end
    // R4: timer mode
    wr(3'b001); cyc(3); wake(); cyc(1);
    // R5: pending interrupt refuses entry
    @(negedge clk); irq_pending = 1'b1; ctl_wr = 1'b1; ctl_wdata = 3'b011;
    @(negedge clk); ctl_wdata = 3'b100;
    @(negedge clk); ctl_wr = 1'b0; irq_pending = 1'b0; ctl_wdata = 3'b000;
    // R11: no-request write
    wr(3'b010); wr(3'b000); cyc(2);
    // R6: wake in the same cycle as a selection change
    sel_main = 1'b1; sel_sub = 1'b1;
    wr(3'b011);
    @(negedge clk); irq_pending = 1'b1; sel_sub = 1'b0;
    @(negedge clk); irq_pending = 1'b0;
    cyc(2);

    // seeded random stretch
    void'($urandom(7));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ctl_wr      = ($urandom_range(0, 3) == 0);
      ctl_wdata   = 3'($urandom_range(0, 7));
      irq_pending = ($urandom_range(0, 5) == 0);
      hold_req    = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 9) == 0) begin
        sel_main = 1'($urandom_range(0, 1));
        sel_sub  = 1'($urandom_range(0, 1));
      end
    end
    @(negedge clk);
    ctl_wr = 1'b0; irq_pending = 1'b0; hold_req = 1'b0;
    cyc(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule